// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter with Character Queue

This block turns parallel characters written by a host into asynchronous serial frames on one output line. A one-cycle enable pulse, `tick16`, paces it. The pulse comes from an external baud divisor and runs at sixteen times the bit rate. Each frame has the following format, which software chooses:

- five to eight data bits;
- an optional even or odd parity bit;
- one or two stop bits.

Characters wait in a queue in front of the shifter. After reset the queue is a single holding register. With `fifo_mode` set it becomes a sixteen-entry first-in first-out store.

The shifter is a state machine with five states. **IDLE** drives the line high. It moves to **START** (transition *load*) in the cycle in which a character is waiting, and pops that character from the queue. **START** drives the low start bit and moves to **DATA** (*start_done*) at the end of the bit. **DATA** shifts the character out least significant bit first. After the last configured bit it moves to **PARITY** (*data_to_parity*) when parity is enabled, otherwise to **STOP** (*data_to_stop*). **PARITY** drives the parity bit and moves to **STOP** (*parity_done*). **STOP** drives the line high for one or two bit times, then returns to **IDLE** (*frame_done*). Each bit lasts sixteen `tick16` pulses. The frame format is captured when the *load* transition is taken. A separate break input holds the line low for as long as it is asserted.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1 and both `hold_empty` and `line_idle` are 1.
- R2: Every frame begins with a start bit driven at 0. The start bit begins one clock after the cycle in which a waiting character is seen in IDLE.
- R3: `len_sel` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The bits go out least significant first, and any higher bits of the character are not sent.
- R4: With `par_en`=1, a parity bit follows the last data bit. It is the XOR of the sent data bits when `par_odd`=0 (even parity), and the inverse of that XOR when `par_odd`=1. With `par_en`=0 there is no parity bit.
- R5: The frame ends with one stop bit at 1 when `two_stop`=0, and two when `two_stop`=1.
- R6: Each bit lasts exactly 16 `tick16` pulses. Clock cycles without a pulse do not advance the frame.
- R7: With `fifo_mode`=0 (the reset mode) the queue holds one character. A write that arrives while that entry is occupied is discarded.
- R8: With `fifo_mode`=1 the queue holds up to 16 characters, which are sent in write order. A write to a full queue is discarded.
- R9: A change of `fifo_mode` empties the queue in the cycle it is seen, and a write in that cycle is discarded. A frame already being shifted completes.
- R10: While `brk`=1, `txd` is 0. Neither the queue nor the timing of the frame in progress is affected.
- R11: `hold_empty` is 1 exactly when the queue holds no character. `line_idle` is 1 exactly when the queue is empty and the shifter is in IDLE.
- R12: The frame format inputs are sampled when a character is loaded. Changes during a frame take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| wr_en | input | 1 | Write a character into the queue |
| wr_data | input | 8 | Character to send |
| fifo_mode | input | 1 | 0: single holding register, 1: 16-entry queue |
| len_sel | input | 2 | Data length select (5 + value bits) |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| two_stop | input | 1 | Two stop bits when 1 |
| brk | input | 1 | Hold the line low |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Queue holds no character |
| line_idle | output | 1 | Queue empty and shifter idle |

## Verification
The bench keeps a behavioural model made of a character queue and a list of frame bits. It compares the model against the design on every clock. The bench runs every length, parity and stop combination and checks that parity covers only the bits actually sent. A design that included unsent high bits in the parity, or swapped the parity sense, would show a wrong level during the parity bit time.

The bench also makes back-to-back writes in single-character mode, and writes eighteen characters into the sixteen-entry queue. A design that accepted the extra writes would send extra frames. A mode switch while characters are queued checks that the queue is flushed but the active frame is not. A break applied mid-frame, together with a format change mid-frame, shows whether break corrupts the frame timing and whether the format is applied late.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;
endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fifo_mode,
    input  logic                            push,
    input  logic [DATA_W-1:0]               push_data,
    input  logic                            pop,
    output logic [DATA_W-1:0]               head,
    output logic                            avail,
    output logic [$clog2(DEPTH+1)-1:0]      count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              mode_q;
    logic              flush, do_push, do_pop;
    logic [CNT_W-1:0]  cap;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign flush   = (fifo_mode != mode_q);
    assign cap     = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign avail   = (count != '0) && !flush;
    assign do_push = push && !flush && (count < cap);
    assign do_pop  = pop && avail;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_mode;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push) wr_ptr <= wrap_inc(wr_ptr);
                if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
                count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R7: outside queue mode at most one entry is ever held
    p_single_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (count <= CNT_W'(1)));

    // R8: a write to a full queue never grows the count
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == cap && !flush) |=> (count <= $past(count)));

    // R9: a mode change leaves the queue empty
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import uart_tx_pkg::*;
#(
    parameter int TICKS  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] head,
    input  frame_cfg_t        cfg,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    localparam int TW = $clog2(TICKS);

    tx_state_e         state_q, state_d;
    logic [TW-1:0]     tick_cnt;
    logic [2:0]        bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              par_q, second_q;
    frame_cfg_t        cfg_q;
    logic              bit_end, load;
    logic [2:0]        last_bit;
    logic [DATA_W-1:0] sent_mask;

    assign bit_end   = tick && (tick_cnt == TW'(TICKS-1));
    assign load      = (state_q == ST_IDLE) && avail;
    assign last_bit  = 3'd4 + {1'b0, cfg_q.len_sel};
    assign sent_mask = 8'hFF >> (2'd3 - cfg.len_sel);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (avail)   state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && bit_cnt == last_bit)
                           state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end && (!cfg_q.two_stop || second_q))
                           state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            second_q <= 1'b0;
            cfg_q    <= '0;
        end else begin
            if (state_q == ST_IDLE)
                tick_cnt <= '0;
            else if (tick)
                tick_cnt <= bit_end ? '0 : tick_cnt + TW'(1);
            if (load) begin
                shreg    <= head;
                cfg_q    <= cfg;
                par_q    <= (^(head & sent_mask)) ^ cfg.par_odd;
                bit_cnt  <= '0;
                second_q <= 1'b0;
            end else if (bit_end) begin
                if (state_q == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (state_q == ST_STOP) second_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pop  = load;
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

    // R6: without a tick the frame does not advance
    p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick) |=> (state_q == $past(state_q) && tick_cnt == $past(tick_cnt)));

    // R3: data bit index stays within the captured length
    p_bitcnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bit_cnt <= last_bit));

    // R4: the parity state is only visited when parity was enabled at load
    p_parity_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY) |-> cfg_q.par_en);

    // R2: a frame starts only right after a load
    p_start_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_START));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_mode,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       brk,
    output logic       txd,
    output logic       hold_empty,
    output logic       line_idle
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [7:0]       head;
    logic             avail, pop, line, busy;
    logic [CNT_W-1:0] count;
    frame_cfg_t       cfg;

    assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    tx_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_queue (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .push(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .avail(avail), .count(count)
    );

    tx_framer #(.TICKS(TICKS), .DATA_W(8)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(avail),
        .head(head), .cfg(cfg), .pop(pop), .line(line), .busy(busy)
    );

    assign txd        = brk ? 1'b0 : line;
    assign hold_empty = (count == '0);
    assign line_idle  = hold_empty && !busy;

    // R11: the shifter only leaves idle when the queue had a character
    p_load_needs_char_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(count) != '0));

    // R7: the shifter pops only when the queue offers data
    p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, tick16, wr_en, fifo_mode, par_en, par_odd, two_stop, brk;
    logic [7:0] wr_data;
    logic [1:0] len_sel;
    logic       txd, hold_empty, line_idle;

    int compared = 0, mismatched = 0, cyc = 0, div = 1, tdc = 0;

    uart_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .brk(brk), .txd(txd), .hold_empty(hold_empty),
        .line_idle(line_idle)
    );

    // reference model state
    logic [7:0] mq[$];
    bit         fr[$];
    int         tcnt;
    bit         mbusy, mode_prev;

    always @(posedge clk) begin : model
        bit flush, take, push_ok;
        int cap, n;
        bit p;
        if (!rst_n) begin
            mq.delete(); fr.delete(); tcnt = 0; mbusy = 0; mode_prev = 0;
        end else begin
            flush = (fifo_mode != mode_prev);
            take  = !mbusy && mq.size() > 0 && !flush;
            if (mbusy) begin
                if (tick16) begin
                    if (tcnt == 15) begin
                        void'(fr.pop_front());
                        tcnt = 0;
                        if (fr.size() == 0) mbusy = 0;
                    end else tcnt++;
                end
            end else if (take) begin
                n = 5 + int'(len_sel);
                p = 0;
                fr.push_back(1'b0);
                for (int i = 0; i < n; i++) begin
                    fr.push_back(mq[0][i]);
                    p ^= mq[0][i];
                end
                if (par_en) fr.push_back(p ^ par_odd);
                fr.push_back(1'b1);
                if (two_stop) fr.push_back(1'b1);
                mbusy = 1; tcnt = 0;
            end
            cap = fifo_mode ? 16 : 1;
            if (flush) mq.delete();
            else begin
                push_ok = wr_en && mq.size() < cap;
                if (take) void'(mq.pop_front());
                if (push_ok) mq.push_back(wr_data);
            end
            mode_prev = fifo_mode;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2 R3 R4 R5 R6 R10 R12 txd", txd, brk ? 1'b0 : (mbusy ? fr[0] : 1'b1));
            chk("R7 R8 R9 R11 hold_empty", hold_empty, mq.size() == 0);
            chk("R11 line_idle", line_idle, mq.size() == 0 && !mbusy);
        end
    end

    initial begin
        tick16 = 0;
        forever begin
            @(negedge clk);
            if (tdc >= div - 1) begin tdc = 0; tick16 = 1; end
            else begin tdc++; tick16 = 0; end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!line_idle) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic s2);
        len_sel = l; par_en = pe; par_odd = po; two_stop = s2;
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_data = 0; fifo_mode = 0; brk = 0;
        set_cfg(2'b11, 0, 0, 0);
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 txd", txd, 1'b1);
        chk("R1 hold_empty", hold_empty, 1'b1);
        chk("R1 line_idle", line_idle, 1'b1);

        // R7: single mode, second write while the holding entry is full is dropped
        div = 1;
        @(negedge clk);
        wr_en = 1; wr_data = 8'hA5;
        @(negedge clk);
        wr_data = 8'h3C;
        @(negedge clk);
        wr_en = 0;
        wait_idle();

        // R3 R4 R5: all formats
        div = 2;
        for (int l = 0; l < 4; l++)
            for (int pm = 0; pm < 3; pm++)
                for (int s = 0; s < 2; s++) begin
                    set_cfg(2'(l), pm != 0, pm == 2, s[0]);
                    put(8'($urandom));
                    wait_idle();
                end

        // R8: queue mode, 18 back-to-back writes
        div = 1;
        set_cfg(2'b11, 1, 0, 0);
        fifo_mode = 1;
        @(negedge clk);
        for (int i = 0; i < 18; i++) begin
            wr_en = 1; wr_data = 8'(i * 37 + 5);
            @(negedge clk);
        end
        wr_en = 0;
        wait_idle();

        // R9: mode change flushes queued characters, active frame completes
        for (int i = 0; i < 5; i++) put(8'(i + 8'h61));
        repeat (20) @(negedge clk);
        fifo_mode = 0; wr_en = 1; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 0;
        wait_idle();

        // R10: break mid-frame, with a write during break
        set_cfg(2'b10, 1, 1, 1);
        put(8'h5A);
        repeat (50) @(negedge clk);
        brk = 1;
        put(8'h81);
        repeat (150) @(negedge clk);
        brk = 0;
        wait_idle();

        // R12: format change mid-frame, next frame uses new format
        set_cfg(2'b00, 0, 0, 0);
        put(8'hFF);
        repeat (10) @(negedge clk);
        set_cfg(2'b11, 1, 0, 1);
        wait_idle();
        put(8'h96);
        wait_idle();

        // R6: sparse ticks
        div = 3;
        put(8'hC3);
        wait_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule